// File: doc/BRIEF.md
# Supervisor Call Exception Router

This block sits beside the execute stage of a processor core and inspects one instruction word per accepted beat. It recognises a supervisor-call instruction in either the 32-bit or the 16-bit encoding and tests its condition code against the NZCV flags. When the call executes, the block sends out an exception request that names the mode the exception is taken to. For calls routed to the hypervisor level, the request also carries a hypervisor syndrome: an exception class and a 16-bit immediate.

Instructions arrive on a valid/ready stream and requests leave on a second valid/ready stream. A request register sits between them. While that register holds a request the sink has not taken, the input is stalled (`in_ready` low), so no request is ever lost or overwritten. When `exc_ready` stays high, every request is a single-cycle pulse one clock after its instruction was accepted. An input word that matches neither encoding raises the plain `no_match` flag in the same cycle.

Pipeline control, vector fetch and saving banked registers belong to other blocks.

Top module: `svc_exc_router`

## Requirements
- R1: With `in_wide`=1 the word is a call when bits 31:28 are not 4'b1111 and bits 27:24 are 4'b1111. The condition code is bits 31:28 and the immediate is bits 23:0.
- R2: With `in_wide`=0 the word is a call when bits 15:8 equal 8'hDF. The immediate is bits 7:0, bits 31:16 are ignored, and the condition code is taken from `it_cond`.
- R3: `no_match` is high combinationally exactly in cycles where `in_valid` is high and the word matches neither encoding. Such a word never produces a request.
- R4: Condition codes use flags N=`flags_nzcv[3]`, Z=[2], C=[1], V=[0]. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 always (counts as conditional). A call that fails its condition raises no request and does not raise `no_match`.
- R5: An accepted call that passes its condition sets `exc_valid` at the next rising clock edge.
- R6: `in_ready` = !`exc_valid` | `exc_ready`. While `exc_valid` is high and `exc_ready` is low, every request output holds its value.
- R7: A call executed with `cur_mode`=5'b11010 (hypervisor) targets 5'b11010 with `exc_class`=6'h11.
- R8: A call executed with `tge`=1, `nonsecure`=1 and `cur_mode`=5'b10000 (user) also targets 5'b11010 with class 6'h11. Every other executed call targets 5'b10011 (supervisor) with `exc_class` and `exc_imm` zero.
- R9: For a hypervisor-routed unconditional call (code 4'b1110), `exc_imm` is bits 15:0 of the word in the 32-bit form and {8'h00, bits 7:0} in the 16-bit form.
- R10: For a hypervisor-routed call whose code is not 4'b1110, `exc_imm` is zero.
- R11: A synchronous active-high `rst` clears `exc_valid`. `exc_target`, `exc_class` and `exc_imm` are zero whenever `exc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction beat valid |
| in_ready | output | 1 | Block can accept an instruction |
| in_word | input | 32 | Instruction word (16-bit form in bits 15:0) |
| in_wide | input | 1 | 1 = 32-bit encoding, 0 = 16-bit encoding |
| it_cond | input | 4 | Condition code for the 16-bit form |
| flags_nzcv | input | 4 | Processor flags N, Z, C, V |
| cur_mode | input | 5 | Current processor mode |
| nonsecure | input | 1 | 1 = Non-secure state |
| tge | input | 1 | Trap-general-exceptions control |
| no_match | output | 1 | Valid word matches neither encoding |
| exc_valid | output | 1 | Exception request valid |
| exc_ready | input | 1 | Request sink ready |
| exc_target | output | 5 | Target mode of the request |
| exc_class | output | 6 | Syndrome exception class |
| exc_imm | output | 16 | Syndrome immediate |

## Verification
The clocked properties assume that the request sink obeys the stream rule: it may hold `exc_ready` low for any number of cycles, and the block alone keeps the payload stable. They also assume that `in_valid` may be asserted while `in_ready` is low and that the word is then not taken. The stimulus does both, including new calls offered during a stall. It drives modes and control bits from the full range, with biased choices so that the user, supervisor and hypervisor modes and every condition code all occur often.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int MODE_W = 5;
  localparam int EC_W   = 6;
  localparam int SIMM_W = 16;
  localparam int COND_W = 4;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_HYP = 5'b11010;
  localparam logic [EC_W-1:0]   EC_SVCALL = 6'h11;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

  typedef struct packed {
    logic              hit;
    logic              uncond;
    logic [COND_W-1:0] code;
    logic [SIMM_W-1:0] imm;
  } svc_dec_t;

  typedef struct packed {
    logic [MODE_W-1:0] target;
    logic [EC_W-1:0]   ec;
    logic [SIMM_W-1:0] imm;
  } svc_req_t;
endpackage

// File: rtl/svc_decode.sv
module svc_decode
  import svc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NARROW_W  = 16,
  parameter logic [7:0] NARROW_OP = 8'hDF
) (
  input  logic [WORD_W-1:0] word,
  input  logic              wide,
  input  logic [COND_W-1:0] it_cond,
  output svc_dec_t          dec
);
  localparam int CTOP = WORD_W - 1;
  localparam int CBOT = WORD_W - COND_W;
  localparam int OTOP = CBOT - 1;
  localparam int OBOT = CBOT - 4;
  localparam int NOPT = NARROW_W - 1;
  localparam int NOPB = NARROW_W - 8;

  logic wide_hit, narrow_hit;
  logic [COND_W-1:0] code_sel;

  always_comb begin
    wide_hit   = (word[CTOP:CBOT] != '1) && (word[OTOP:OBOT] == 4'hF);
    narrow_hit = (word[NOPT:NOPB] == NARROW_OP);
    code_sel   = wide ? word[CTOP:CBOT] : it_cond;
    dec.hit    = wide ? wide_hit : narrow_hit;
    dec.code   = code_sel;
    dec.uncond = (code_sel == COND_ALWAYS);
    if (wide) dec.imm = word[SIMM_W-1:0];
    else      dec.imm = {{(SIMM_W-8){1'b0}}, word[7:0]};
  end

  // narrow immediates are zero-extended (R9)
  always_comb begin
    if (!wide && dec.hit)
      assert_narrow_zext_R9: assert (dec.imm[SIMM_W-1:8] == '0);
  end
endmodule

// File: rtl/svc_cond_eval.sv
module svc_cond_eval
  import svc_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  logic [3:0]        nzcv,
  output logic              pass
);
  logic fn, fz, fc, fv, base;

  always_comb begin
    fn = nzcv[3];
    fz = nzcv[2];
    fc = nzcv[1];
    fv = nzcv[0];
    unique case (code[COND_W-1:1])
      3'd0: base = fz;
      3'd1: base = fc;
      3'd2: base = fn;
      3'd3: base = fv;
      3'd4: base = fc & ~fz;
      3'd5: base = (fn == fv);
      3'd6: base = ~fz & (fn == fv);
      default: base = 1'b1;
    endcase
    // odd codes invert, except the always-true pair
    if (code[COND_W-1:1] == 3'd7) pass = 1'b1;
    else                           pass = base ^ code[0];
  end
endmodule

// File: rtl/svc_route.sv
module svc_route
  import svc_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              nonsecure,
  input  logic              tge,
  input  svc_dec_t          dec,
  output svc_req_t          req
);
  logic to_hyp;

  always_comb begin
    to_hyp = (mode == MODE_HYP) || (tge && nonsecure && mode == MODE_USR);
    req = '0;
    if (to_hyp) begin
      req.target = MODE_HYP;
      req.ec     = EC_SVCALL;
      req.imm    = dec.uncond ? dec.imm : '0;
    end else begin
      req.target = MODE_SVC;
    end
  end
endmodule

// File: rtl/svc_exc_router.sv
module svc_exc_router
  import svc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_wide,
  input  logic [3:0]        it_cond,
  input  logic [3:0]        flags_nzcv,
  input  logic [4:0]        cur_mode,
  input  logic              nonsecure,
  input  logic              tge,
  output logic              no_match,
  output logic              exc_valid,
  input  logic              exc_ready,
  output logic [4:0]        exc_target,
  output logic [5:0]        exc_class,
  output logic [15:0]       exc_imm
);
  svc_dec_t dec;
  svc_req_t req_d, req_q;
  logic     pass, accept, fire, valid_q;

  svc_decode #(.WORD_W(WORD_W)) u_dec (
    .word(in_word), .wide(in_wide), .it_cond(it_cond), .dec(dec)
  );

  svc_cond_eval u_cond (.code(dec.code), .nzcv(flags_nzcv), .pass(pass));

  svc_route u_route (
    .mode(cur_mode), .nonsecure(nonsecure), .tge(tge), .dec(dec), .req(req_d)
  );

  assign in_ready = !valid_q || exc_ready;
  assign accept   = in_valid && in_ready;
  assign fire     = accept && dec.hit && pass;
  assign no_match = in_valid && !dec.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      req_q   <= '0;
    end else if (fire) begin
      valid_q <= 1'b1;
      req_q   <= req_d;
    end else if (in_ready) begin
      valid_q <= 1'b0;
      req_q   <= '0;
    end
  end

  assign exc_valid  = valid_q;
  assign exc_target = req_q.target;
  assign exc_class  = req_q.ec;
  assign exc_imm    = req_q.imm;

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    exc_valid && !exc_ready |=> exc_valid && $stable(exc_target)
      && $stable(exc_class) && $stable(exc_imm));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |-> exc_target == '0 && exc_class == '0 && exc_imm == '0);

  assert_nomatch_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    no_match && in_ready |=> !exc_valid);

  assert_class_pairs_target_R7: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> ((exc_target == MODE_HYP) == (exc_class == EC_SVCALL)));

  assert_svc_plain_R8: assert property (@(posedge clk) disable iff (rst)
    exc_valid && exc_target == MODE_SVC |-> exc_imm == '0);

  assert_request_follows_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(exc_valid) |-> $past(in_valid && in_ready));
endmodule

// File: tb/sim_svc_exc_router.sv
`timescale 1ns/100ps
module sim_svc_exc_router;
  localparam logic [4:0] USR = 5'b10000, SVC = 5'b10011, HYP = 5'b11010;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_wide = 0, nonsecure = 0, tge = 0, exc_ready = 1;
  logic [31:0] in_word = 0;
  logic [3:0] it_cond = 0, flags_nzcv = 0;
  logic [4:0] cur_mode = 0;
  logic in_ready, no_match, exc_valid;
  logic [4:0] exc_target;
  logic [5:0] exc_class;
  logic [15:0] exc_imm;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_v; int m_t, m_c, m_i;

  always #2.5 clk = ~clk;

  svc_exc_router u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_wide(in_wide), .it_cond(it_cond),
    .flags_nzcv(flags_nzcv), .cur_mode(cur_mode), .nonsecure(nonsecure),
    .tge(tge), .no_match(no_match), .exc_valid(exc_valid),
    .exc_ready(exc_ready), .exc_target(exc_target), .exc_class(exc_class),
    .exc_imm(exc_imm)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit cond_ok(int code, int f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (code)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      default: return 1;
    endcase
  endfunction

  task automatic step(bit v, logic [31:0] w, bit wd, int itc, int f,
                      int md, bit ns, bit tg, bit rdy);
    bit hit, fire, hyp, rdy_m; int code, nv, nt, nc, ni;
    in_valid = v; in_word = w; in_wide = wd; it_cond = itc[3:0];
    flags_nzcv = f[3:0]; cur_mode = md[4:0]; nonsecure = ns; tge = tg;
    exc_ready = rdy;
    #1;
    if (wd) begin
      hit = (w[31:28] != 4'hF) && (w[27:24] == 4'hF); code = w[31:28];
    end else begin
      hit = (w[15:8] == 8'hDF); code = itc;
    end
    rdy_m = !m_v || rdy;
    chk("R6 in_ready", in_ready, rdy_m);
    chk("R3 no_match", no_match, v && !hit);
    fire = v && rdy_m && hit && cond_ok(code, f);
    hyp = (md == HYP) || (tg && ns && md == USR);
    nv = m_v; nt = m_t; nc = m_c; ni = m_i;
    if (fire) begin
      nv = 1;
      nt = hyp ? HYP : SVC;
      nc = hyp ? 'h11 : 0;
      ni = (!hyp || code != 14) ? 0 : (wd ? w[15:0] : w[7:0]);
    end else if (rdy_m) begin
      nv = 0; nt = 0; nc = 0; ni = 0;
    end
    @(negedge clk);
    m_v = nv; m_t = nt; m_c = nc; m_i = ni;
    chk("R5 exc_valid", exc_valid, m_v);
    chk("R8 exc_target", exc_target, m_t);
    chk("R7 exc_class", exc_class, m_c);
    chk("R9 R10 exc_imm", exc_imm, m_i);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    m_v = 0; m_t = 0; m_c = 0; m_i = 0;
    // R11 reset state
    chk("R11 reset valid", exc_valid, 0);
    chk("R11 reset payload", {exc_target, exc_class, exc_imm}, 0);
    // R1 wide always call from supervisor mode
    step(1, 32'hEF00_1234, 1, 0, 0, SVC, 0, 0, 1);
    // R7 R9 wide call in hypervisor mode, low 16 bits of imm24
    step(1, 32'hEF12_ABCD, 1, 0, 0, HYP, 0, 0, 1);
    // R2 R9 narrow call, upper half ignored
    step(1, 32'hABCD_DF5A, 0, 14, 0, HYP, 1, 0, 1);
    // R1 condition 1111 is not a call
    step(1, 32'hFF00_0001, 1, 0, 0, HYP, 0, 0, 1);
    // R3 random non-call word
    step(1, 32'h1234_5678, 1, 0, 0, HYP, 0, 0, 1);
    // R4 EQ fails with Z clear, passes with Z set; R10 imm zero
    step(1, 32'h0F00_0042, 1, 0, 4'b0000, HYP, 0, 0, 1);
    step(1, 32'h0F00_0042, 1, 0, 4'b0100, HYP, 0, 0, 1);
    // R8 trap from non-secure user, then secure, then tge clear
    step(1, 32'hEF00_0007, 1, 0, 0, USR, 1, 1, 1);
    step(1, 32'hEF00_0007, 1, 0, 0, USR, 0, 1, 1);
    step(1, 32'hEF00_0007, 1, 0, 0, USR, 1, 0, 1);
    // R6 stall: request held, new call offered but not taken
    step(1, 32'hEF00_0099, 1, 0, 0, HYP, 0, 0, 0);
    step(1, 32'hEF00_0055, 1, 0, 0, SVC, 0, 0, 0);
    step(1, 32'hEF00_0055, 1, 0, 0, SVC, 0, 0, 1);
    step(0, 0, 1, 0, 0, SVC, 0, 0, 1);
    // R4 sweep every code on narrow form with every flag pattern
    for (int cd = 0; cd < 16; cd++)
      for (int fl = 0; fl < 16; fl++)
        step(1, 32'h0000_DF33, 0, cd, fl, HYP, 0, 0, 1);
    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      int kind = $urandom_range(0, 3);
      logic [31:0] w = $urandom;
      bit wd = 1;
      int md;
      if (kind == 0) w[27:24] = 4'hF;
      else if (kind == 1) begin wd = 0; w[15:8] = 8'hDF; end
      else if (kind == 2) begin w[31:28] = 4'hE; w[27:24] = 4'hF; end
      else wd = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: md = USR; 1: md = SVC; 2: md = HYP; default: md = $urandom_range(0, 31);
      endcase
      step($urandom_range(0, 4) != 0, w, wd, $urandom_range(0, 15),
           $urandom_range(0, 15), md, $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 3) != 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule